// File: doc/BRIEF.md
# Single-Channel Result Picker for a Four-Result Converter

This block sits next to a converter that stores four results after each conversion and hands them out one per read strobe. When the converter's end-of-conversion line (`conv_done_n`) falls, the block runs a fixed burst of four read strobes without any processor. Each strobe has the same timing, counted in system-clock cycles, and the chip select stays low for the whole burst. Because the burst always has four strobes, the converter's internal result pointer ends each sequence back at the first result.

A read index follows which result is on the bus. When the index equals the 2-bit `pick_sel` input, the block captures the bus word into an output register during the last low cycle of that strobe. It raises `word_vld` for one cycle when the new word appears.

The controller has three states. IDLE waits for a falling edge of `conv_done_n`. STROBE_LO drives the read strobe low for `LOW_CYC` cycles. STROBE_HI drives it high for the same number of cycles. The transitions are:

- IDLE to STROBE_LO on a falling edge.
- STROBE_LO to STROBE_HI when the low time has elapsed.
- STROBE_HI to STROBE_LO when the high time has elapsed and fewer than four strobes have been issued.
- STROBE_HI to IDLE after the high time of the fourth strobe.

Top module: `pick_reader`

## Requirements
- R1: A synchronous active-high `rst` forces IDLE: `rd_n` and `cs_n` are 1, the read index is 0, `word_q` is 0 and `word_vld` is 0.
- R2: A falling edge of `conv_done_n` seen in IDLE (sampled 1 on one rising clock edge, then 0 on the next) drives `rd_n` and `cs_n` low from the next clock cycle onward.
- R3: Each burst has exactly four `rd_n` low pulses. Each pulse is low for `LOW_CYC` cycles and is followed by `LOW_CYC` high cycles.
- R4: `cs_n` stays low from the first strobe until the end of the high time after the fourth strobe, then returns to 1.
- R5: `pick_sel` selects the captured result by the index of the strobe in the burst: 00 = first, 01 = second, 10 = third, 11 = fourth.
- R6: The captured word is the value of `bus_data` in the last low cycle of the selected strobe, and it appears on `word_q` in the cycle after.
- R7: `word_vld` is 1 for exactly one cycle, the cycle in which `word_q` first shows a newly captured word.
- R8: A falling edge of `conv_done_n` during a burst is ignored. The burst keeps its four strobes, and no second burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobe timing is counted from it |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_n | input | 1 | Converter end-of-conversion, active low |
| pick_sel | input | 2 | Index of the result to keep |
| bus_data | input | DATA_W | Converter data bus |
| rd_n | output | 1 | Read strobe to the converter, active low |
| cs_n | output | 1 | Chip select to the converter, active low |
| word_q | output | DATA_W | Last captured result |
| word_vld | output | 1 | One-cycle pulse when `word_q` updates |

## Verification
The bench builds the block with `DATA_W` = 16 and `LOW_CYC` = 2, so one burst lasts 16 cycles. That short burst lets every select code, back-to-back conversions and a retrigger placed inside a burst all fit in a short run. The bus word changes every cycle, so capturing one cycle early or late gives a wrong `word_q`. `LOW_CYC` = 2 also separates the first low cycle from the last one, which tests where the capture happens.

// File: rtl/pick_reader_pkg.sv
package pick_reader_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_STROBE_LO = 2'd1,
        ST_STROBE_HI = 2'd2
    } pr_state_t;

    localparam int PR_READS = 4;
    localparam int PR_SEL_W = 2;
endpackage

// File: rtl/pr_fall_detect.sv
module pr_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic sig_n,
    output logic fall
);
    logic sig_d;

    always_ff @(posedge clk) begin
        if (rst) sig_d <= 1'b1;
        else     sig_d <= sig_n;
    end

    assign fall = sig_d & ~sig_n;
endmodule

// File: rtl/pr_burst_fsm.sv
module pr_burst_fsm
    import pick_reader_pkg::*;
#(
    parameter int LOW_CYC = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    output pr_state_t           state_o,
    output logic [PR_SEL_W-1:0] idx_o,
    output logic                last_low,
    output logic                rd_n,
    output logic                cs_n
);
    localparam int TW = (LOW_CYC > 1) ? $clog2(LOW_CYC) : 1;
    localparam logic [TW-1:0] T_END = TW'(LOW_CYC - 1);
    localparam logic [PR_SEL_W-1:0] IDX_LAST = PR_SEL_W'(PR_READS - 1);

    pr_state_t           state, state_nx;
    logic [TW-1:0]       tcnt;
    logic [PR_SEL_W-1:0] idx;
    logic                t_end;

    assign t_end = (tcnt == T_END);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start) state_nx = ST_STROBE_LO;
            ST_STROBE_LO: if (t_end) state_nx = ST_STROBE_HI;
            ST_STROBE_HI: if (t_end) state_nx = (idx == IDX_LAST) ? ST_IDLE : ST_STROBE_LO;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tcnt  <= '0;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state_nx != state) tcnt <= '0;
            else if (state != ST_IDLE) tcnt <= tcnt + 1'b1;
            if (state == ST_IDLE) idx <= '0;
            else if (state == ST_STROBE_HI && t_end) idx <= idx + 1'b1;
        end
    end

    always_comb begin
        rd_n     = (state != ST_STROBE_LO);
        cs_n     = (state == ST_IDLE);
        last_low = (state == ST_STROBE_LO) && t_end;
    end

    assign state_o = state;
    assign idx_o   = idx;

    AST_BURST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE_HI && t_end && idx == IDX_LAST) |=> (state == ST_IDLE)) else $error("AST_BURST_ENDS"); // R3
endmodule

// File: rtl/pr_word_capture.sv
module pr_word_capture
    import pick_reader_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                last_low,
    input  logic [PR_SEL_W-1:0] idx,
    input  logic [PR_SEL_W-1:0] sel,
    input  logic [DATA_W-1:0]   data,
    output logic                le,
    output logic [DATA_W-1:0]   word_q,
    output logic                word_vld
);
    assign le = last_low && (idx == sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= le;
            if (le) word_q <= data;
        end
    end
endmodule

// File: rtl/pick_reader.sv
module pick_reader
    import pick_reader_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done_n,
    input  logic [1:0]        pick_sel,
    input  logic [DATA_W-1:0] bus_data,
    output logic              rd_n,
    output logic              cs_n,
    output logic [DATA_W-1:0] word_q,
    output logic              word_vld
);
    logic                fall, last_low, le;
    pr_state_t           state;
    logic [PR_SEL_W-1:0] idx;

    pr_fall_detect u_fall (
        .clk(clk), .rst(rst), .sig_n(conv_done_n), .fall(fall)
    );

    pr_burst_fsm #(.LOW_CYC(LOW_CYC)) u_fsm (
        .clk(clk), .rst(rst), .start(fall), .state_o(state), .idx_o(idx),
        .last_low(last_low), .rd_n(rd_n), .cs_n(cs_n)
    );

    pr_word_capture #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .last_low(last_low), .idx(idx), .sel(pick_sel),
        .data(bus_data), .le(le), .word_q(word_q), .word_vld(word_vld)
    );

    AST_START_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && fall) |=> (!rd_n && !cs_n)) else $error("AST_START_ON_FALL"); // R2
    AST_LATCH_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        le |-> (!rd_n && !cs_n)) else $error("AST_LATCH_IN_LOW"); // R6
    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        word_vld |=> !word_vld) else $error("AST_VLD_SINGLE"); // R7
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !le |=> $stable(word_q)) else $error("AST_WORD_HOLD"); // R6
    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STROBE_LO && fall) |=> (state != ST_IDLE)) else $error("AST_NO_RETRIGGER"); // R8
endmodule

// File: tb/pick_reader_bench.sv
`timescale 1ns/1ps
module pick_reader_bench;
    localparam int DW = 16;
    localparam int LC = 2;
    localparam int BURST = 8 * LC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          conv_done_n = 1'b1;
    logic [1:0]    pick_sel = 2'd0;
    logic [DW-1:0] bus_data = 16'h1000;
    logic          rd_n, cs_n, word_vld;
    logic [DW-1:0] word_q;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // reference model state
    int            m_busy = 0;
    int            m_pos = 0;
    logic          m_prev = 1'b1;
    logic [DW-1:0] m_word = '0;
    logic          m_vld = 1'b0;
    int            rd_falls = 0;
    logic          rd_prev = 1'b1;

    always #2.5 clk = ~clk;

    pick_reader #(.DATA_W(DW), .LOW_CYC(LC)) u_pick_reader (
        .clk(clk), .rst(rst), .conv_done_n(conv_done_n), .pick_sel(pick_sel),
        .bus_data(bus_data), .rd_n(rd_n), .cs_n(cs_n), .word_q(word_q), .word_vld(word_vld)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_pos = 0; m_prev = 1'b1; m_word = '0; m_vld = 1'b0;
        end else begin
            m_vld = 1'b0;
            if (m_busy != 0 && (m_pos % (2*LC)) == LC-1 && (m_pos / (2*LC)) == int'(pick_sel)) begin
                m_word = bus_data;
                m_vld  = 1'b1;
            end
            if (m_busy != 0) begin
                m_pos++;
                if (m_pos == BURST) m_busy = 0;
            end else if (m_prev && !conv_done_n) begin
                m_busy = 1; m_pos = 0;
            end
            m_prev = conv_done_n;
        end
    end

    function automatic logic exp_rd();
        return !(m_busy != 0 && (m_pos % (2*LC)) < LC);
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d actual %h expected %h", tag, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk("R3 rd_n", DW'(rd_n), DW'(exp_rd()));
            chk("R4 cs_n", DW'(cs_n), DW'(m_busy == 0));
            chk("R5/R6 word_q", word_q, m_word);
            chk("R7 word_vld", DW'(word_vld), DW'(m_vld));
            if (rd_prev && !rd_n) rd_falls++;
            rd_prev = rd_n;
        end
        bus_data = bus_data + 16'h1357;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_burst(input logic [1:0] sel);
        pick_sel = sel;
        @(negedge clk);
        conv_done_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R2 rd_n low after fall", DW'(rd_n), DW'(0));
        chk("R2 cs_n low after fall", DW'(cs_n), DW'(0));
        wait_cyc(4);
        conv_done_n = 1'b1;
        wait_cyc(BURST + 4);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        chk("R1 rd_n reset", DW'(rd_n), DW'(1));
        chk("R1 cs_n reset", DW'(cs_n), DW'(1));
        chk("R1 word_q reset", word_q, '0);
        chk("R1 word_vld reset", DW'(word_vld), DW'(0));

        for (int s = 0; s < 4; s++) begin
            rd_falls = 0;
            run_burst(2'(s));
            chk("R3 four strobes per burst", DW'(rd_falls), DW'(4));
            chk("R4 cs_n high after burst", DW'(cs_n), DW'(1));
        end

        // R8: extra falling edge inside a burst
        rd_falls = 0;
        pick_sel = 2'd2;
        conv_done_n = 1'b0;
        wait_cyc(5);
        conv_done_n = 1'b1;
        wait_cyc(1);
        conv_done_n = 1'b0;
        wait_cyc(3);
        conv_done_n = 1'b1;
        wait_cyc(BURST + 10);
        chk("R8 retrigger ignored strobe count", DW'(rd_falls), DW'(4));

        // back-to-back conversions
        rd_falls = 0;
        pick_sel = 2'd3;
        conv_done_n = 1'b0;
        wait_cyc(BURST + 1);
        conv_done_n = 1'b1;
        wait_cyc(1);
        conv_done_n = 1'b0;
        wait_cyc(BURST + 4);
        conv_done_n = 1'b1;
        chk("R3 two bursts eight strobes", DW'(rd_falls), DW'(8));

        // reset in the middle of a burst
        conv_done_n = 1'b0;
        wait_cyc(6);
        rst = 1'b1;
        conv_done_n = 1'b1;
        wait_cyc(2);
        rst = 1'b0;
        chk("R1 mid-burst reset rd_n", DW'(rd_n), DW'(1));
        chk("R1 mid-burst reset word_q", word_q, '0);
        wait_cyc(5);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule